// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side on every lookup. One is a global predictor whose table of 2-bit saturating counters is indexed by the shared outcome history of recent branches. The other is a two-level local predictor. Its first level holds a short outcome history for each branch slot, and that history selects a 3-bit saturating counter in the second level. A chooser table of 2-bit counters, indexed by the global history, decides which component's answer becomes the final prediction.

The lookup side is purely combinational. A branch address goes in, and the final prediction comes out in the same cycle together with both component predictions and the chooser's pick. The front end keeps the two component predictions and returns them on the update side once the branch resolves. In one clock the update trains both component counters, trains the chooser when the components disagreed, and shifts the real outcome into the global history and into the branch's local history. Histories are not repaired speculatively: the global history advances only on updates.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, and until the first update, every lookup returns not-taken from both components, the local pick (`lk_use_global` = 0) and a final prediction of not-taken. Reset values are: local counters 3, global counters 1, chooser counters 1, all histories 0.
- R2: The local path selects one of 64 10-bit histories with address bits [7:2]. That history selects one of 1024 3-bit counters, and `lk_local_pred` is bit 2 of that counter (taken when the value is 4 to 7).
- R3: The global path uses the 10-bit global history to select one of 1024 2-bit counters, and `lk_global_pred` is bit 1 of that counter (taken when the value is 2 or 3).
- R4: The chooser entry selected by the global history drives `lk_use_global` (1 when the value is 2 or 3). `lk_pred` equals `lk_global_pred` when it is 1 and `lk_local_pred` otherwise, all within the cycle of the lookup.
- R5: An update (`up_valid` = 1) shifts `up_taken` (1 = taken) into bit 0 of the global history and into bit 0 of the local history at `up_pc[7:2]`. The oldest bit is dropped.
- R6: An update moves the local counter selected by the pre-update local history of `up_pc`, and the global counter selected by the pre-update global history, by +1 when taken and -1 when not taken, saturating at 0 and 7 (local) or at 0 and 3 (global).
- R7: The chooser entry at the pre-update global history changes only when `up_global_pred` differs from `up_local_pred`. It moves +1 when the global prediction matched `up_taken` and -1 otherwise, saturating at 0 and 3.
- R8: While `up_valid` is 0, no history or counter changes, whatever the other update inputs hold.
- R9: A lookup in the same cycle as an update sees the state from before that update. The update takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_pc | input | PC_W | Branch address to predict |
| lk_pred | output | 1 | Final prediction, 1 = taken |
| lk_global_pred | output | 1 | Global component prediction |
| lk_local_pred | output | 1 | Local component prediction |
| lk_use_global | output | 1 | Chooser pick, 1 = global component |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real outcome, 1 = taken |
| up_global_pred | input | 1 | Global prediction recorded at lookup |
| up_local_pred | input | 1 | Local prediction recorded at lookup |

## Verification
A corrupted history or counter does not show up as a bad value in a visible register. It shows up as a wrong component bit or a wrong chooser pick on some later lookup. That lookup may come one cycle later for a global history fault, or only when a branch next maps to the damaged entry. The bench therefore keeps a full reference model of every table. It compares all four lookup outputs on every branch across biased random streams, loop patterns, saturation runs and aliasing addresses, so a fault is caught at the first lookup that reads the faulty entry.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Weakly-low starting value of an n-bit saturating counter (just below the taken threshold)
  function automatic int weak_low(input int width);
    return (1 << (width - 1)) - 1;
  endfunction

  // Which component the chooser picks
  typedef enum logic {
    PICK_LOCAL  = 1'b0,
    PICK_GLOBAL = 1'b1
  } pick_e;

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W  = 10,
  parameter int CTR_W  = 2,
  parameter int INIT   = 1,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(INIT);
  localparam logic [CTR_W-1:0] CTR_ONE  = CTR_W'(1);

  logic [CTR_W-1:0] mem_q [DEPTH];
  logic [CTR_W-1:0] wr_cur;
  logic [CTR_W-1:0] wr_nxt;

  assign rd_ctr = mem_q[rd_idx];
  assign wr_cur = mem_q[wr_idx];

  // Saturating step of the entry being trained
  always_comb begin
    wr_nxt = wr_cur;
    if (wr_up) begin
      if (wr_cur != CTR_MAX) wr_nxt = wr_cur + CTR_ONE;
    end else begin
      if (wr_cur != CTR_MIN) wr_nxt = wr_cur - CTR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_nxt;
    end
  end

endmodule

// File: rtl/bp_local_hist.sv
module bp_local_hist #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_hist_old
);

  logic [HIST_W-1:0] hist_q [DEPTH];
  logic [HIST_W-1:0] wr_hist_new;

  assign rd_hist     = hist_q[rd_idx];
  assign wr_hist_old = hist_q[wr_idx];

  always_comb begin
    wr_hist_new = {wr_hist_old[HIST_W-2:0], wr_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= wr_hist_new;
    end
  end

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int PC_W      = 32,
  parameter int LHT_IDX_W = 6,
  parameter int LHT_LSB   = 2,
  parameter int HIST_W    = 10,
  parameter int LCTR_W    = 3,
  parameter int GCTR_W    = 2,
  parameter int SEL_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  output logic            lk_global_pred,
  output logic            lk_local_pred,
  output logic            lk_use_global,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_global_pred,
  input  logic            up_local_pred
);

  import bp_pkg::*;

  localparam int LCTR_INIT = weak_low(LCTR_W);
  localparam int GCTR_INIT = weak_low(GCTR_W);
  localparam int SEL_INIT  = weak_low(SEL_W);

  logic                 rst_n_s;
  logic [HIST_W-1:0]    ghr_q;
  logic [HIST_W-1:0]    ghr_d;
  logic [LHT_IDX_W-1:0] lk_slot;
  logic [LHT_IDX_W-1:0] up_slot;
  logic [HIST_W-1:0]    lk_lhist;
  logic [HIST_W-1:0]    up_lhist;
  logic [LCTR_W-1:0]    lk_lctr;
  logic [GCTR_W-1:0]    lk_gctr;
  logic [SEL_W-1:0]     lk_sel;
  logic                 sel_wr_en;
  logic                 sel_wr_up;
  pick_e                pick;
  logic                 pc_unused;

  bp_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  assign lk_slot = lk_pc[LHT_LSB +: LHT_IDX_W];
  assign up_slot = up_pc[LHT_LSB +: LHT_IDX_W];

  // Global history: next state and register
  always_comb begin
    ghr_d = ghr_q;
    if (up_valid) ghr_d = {ghr_q[HIST_W-2:0], up_taken};
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ghr_q <= '0;
    end else begin
      ghr_q <= ghr_d;
    end
  end

  // First level of the local component
  bp_local_hist #(
    .IDX_W  (LHT_IDX_W),
    .HIST_W (HIST_W)
  ) u_lhist (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .rd_idx      (lk_slot),
    .rd_hist     (lk_lhist),
    .wr_en       (up_valid),
    .wr_idx      (up_slot),
    .wr_bit      (up_taken),
    .wr_hist_old (up_lhist)
  );

  // Second level of the local component
  bp_ctr_table #(
    .IDX_W (HIST_W),
    .CTR_W (LCTR_W),
    .INIT  (LCTR_INIT)
  ) u_lctr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rd_idx (lk_lhist),
    .rd_ctr (lk_lctr),
    .wr_en  (up_valid),
    .wr_idx (up_lhist),
    .wr_up  (up_taken)
  );

  // Global component
  bp_ctr_table #(
    .IDX_W (HIST_W),
    .CTR_W (GCTR_W),
    .INIT  (GCTR_INIT)
  ) u_gctr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rd_idx (ghr_q),
    .rd_ctr (lk_gctr),
    .wr_en  (up_valid),
    .wr_idx (ghr_q),
    .wr_up  (up_taken)
  );

  // Chooser trains only on disagreement, toward the component that was right
  always_comb begin
    sel_wr_en = up_valid & (up_global_pred ^ up_local_pred);
    sel_wr_up = (up_global_pred == up_taken);
  end

  bp_ctr_table #(
    .IDX_W (HIST_W),
    .CTR_W (SEL_W),
    .INIT  (SEL_INIT)
  ) u_sel (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rd_idx (ghr_q),
    .rd_ctr (lk_sel),
    .wr_en  (sel_wr_en),
    .wr_idx (ghr_q),
    .wr_up  (sel_wr_up)
  );

  // Lookup outputs
  always_comb begin
    lk_local_pred  = lk_lctr[LCTR_W-1];
    lk_global_pred = lk_gctr[GCTR_W-1];
    pick           = pick_e'(lk_sel[SEL_W-1]);
    lk_use_global  = (pick == PICK_GLOBAL);
    lk_pred        = (pick == PICK_GLOBAL) ? lk_global_pred : lk_local_pred;
  end

  assign pc_unused = ^{lk_pc, up_pc, lk_lctr, lk_gctr, lk_sel};

endmodule

// File: rtl/tourney_predictor_chk.sv
module tourney_predictor_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   lk_pc,
  input logic              lk_pred,
  input logic              lk_global_pred,
  input logic              lk_local_pred,
  input logic              lk_use_global,
  input logic              up_valid,
  input logic              up_taken,
  input logic [HIST_W-1:0] ghr_q
);

  logic started;
  logic quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      quiet   <= 1'b1;
    end else begin
      started <= 1'b1;
      if (up_valid) quiet <= 1'b0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (!lk_pred && !lk_global_pred && !lk_local_pred && !lk_use_global));

  // R5
  ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && up_valid) |=> (ghr_q == {$past(ghr_q[HIST_W-2:0]), $past(up_taken)}));

  // R8
  ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !up_valid) |=> (ghr_q == $past(ghr_q)));

  // R8
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !up_valid) |=> ((lk_pc != $past(lk_pc)) ||
      (lk_pred == $past(lk_pred) && lk_global_pred == $past(lk_global_pred) &&
       lk_local_pred == $past(lk_local_pred) && lk_use_global == $past(lk_use_global))));

endmodule

bind tourney_predictor tourney_predictor_chk #(
  .PC_W   (PC_W),
  .HIST_W (HIST_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_s),
  .lk_pc          (lk_pc),
  .lk_pred        (lk_pred),
  .lk_global_pred (lk_global_pred),
  .lk_local_pred  (lk_local_pred),
  .lk_use_global  (lk_use_global),
  .up_valid       (up_valid),
  .up_taken       (up_taken),
  .ghr_q          (ghr_q)
);

// File: tb/tourney_predictor_test.sv
module tourney_predictor_test;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 1234;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_pred;
  logic        lk_global_pred;
  logic        lk_local_pred;
  logic        lk_use_global;
  logic        up_valid;
  logic [31:0] up_pc;
  logic        up_taken;
  logic        up_global_pred;
  logic        up_local_pred;

  int n_chk;
  int n_err;
  bit done;

  // Reference model state
  bit [2:0] m_lc [1024];
  bit [1:0] m_gc [1024];
  bit [1:0] m_ch [1024];
  bit [9:0] m_lh [64];
  bit [9:0] m_ghr;

  tourney_predictor uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_pc          (lk_pc),
    .lk_pred        (lk_pred),
    .lk_global_pred (lk_global_pred),
    .lk_local_pred  (lk_local_pred),
    .lk_use_global  (lk_use_global),
    .up_valid       (up_valid),
    .up_pc          (up_pc),
    .up_taken       (up_taken),
    .up_global_pred (up_global_pred),
    .up_local_pred  (up_local_pred)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_local(input logic [31:0] pc);
    return m_lc[m_lh[pc[7:2]]][2];
  endfunction

  function automatic bit exp_global();
    return m_gc[m_ghr][1];
  endfunction

  function automatic bit exp_sel();
    return m_ch[m_ghr][1];
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 1024; i++) begin
      m_lc[i] = 3'd3;
      m_gc[i] = 2'd1;
      m_ch[i] = 2'd1;
    end
    for (int i = 0; i < 64; i++) m_lh[i] = '0;
    m_ghr = '0;
  endfunction

  function automatic void model_update(input logic [31:0] pc, input bit t, input bit gp, input bit lp);
    bit [9:0] lh;
    lh = m_lh[pc[7:2]];
    if (t) begin
      if (m_lc[lh] != 3'd7) m_lc[lh] = m_lc[lh] + 3'd1;
      if (m_gc[m_ghr] != 2'd3) m_gc[m_ghr] = m_gc[m_ghr] + 2'd1;
    end else begin
      if (m_lc[lh] != 3'd0) m_lc[lh] = m_lc[lh] - 3'd1;
      if (m_gc[m_ghr] != 2'd0) m_gc[m_ghr] = m_gc[m_ghr] - 2'd1;
    end
    if (gp != lp) begin
      if (gp == t) begin
        if (m_ch[m_ghr] != 2'd3) m_ch[m_ghr] = m_ch[m_ghr] + 2'd1;
      end else begin
        if (m_ch[m_ghr] != 2'd0) m_ch[m_ghr] = m_ch[m_ghr] - 2'd1;
      end
    end
    m_lh[pc[7:2]] = {lh[8:0], t};
    m_ghr = {m_ghr[8:0], t};
  endfunction

  task automatic chk(input string req, input string phase, input string what,
                     input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s (%s) %s actual=%0b expected=%0b", req, phase, what, act, expv);
    end
  endtask

  task automatic check_lookup(input string phase, input logic [31:0] pc);
    bit el, eg, es;
    el = exp_local(pc);
    eg = exp_global();
    es = exp_sel();
    chk("R2", phase, "local_pred",  lk_local_pred,  el);
    chk("R3", phase, "global_pred", lk_global_pred, eg);
    chk("R4", phase, "use_global",  lk_use_global,  es);
    chk("R4", phase, "pred",        lk_pred,        es ? eg : el);
  endtask

  // Lookup and update in the same cycle; the lookup must see pre-update state (R9)
  task automatic branch(input logic [31:0] pc, input bit t, input string phase);
    bit el, eg;
    @(negedge clk);
    el = exp_local(pc);
    eg = exp_global();
    lk_pc          = pc;
    up_valid       = 1'b1;
    up_pc          = pc;
    up_taken       = t;
    up_global_pred = eg;
    up_local_pred  = el;
    #1;
    check_lookup(phase, pc);
    @(posedge clk);
    model_update(pc, t, eg, el);
    #1;
    up_valid = 1'b0;
  endtask

  // Lookup only, no update
  task automatic probe(input logic [31:0] pc, input string phase);
    @(negedge clk);
    lk_pc    = pc;
    up_valid = 1'b0;
    #1;
    check_lookup(phase, pc);
  endtask

  // Update inputs toggle while the strobe stays low (R8)
  task automatic idle_noise();
    @(negedge clk);
    up_valid       = 1'b0;
    up_pc          = $urandom;
    up_taken       = 1'($urandom);
    up_global_pred = 1'($urandom);
    up_local_pred  = 1'($urandom);
    @(posedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int bias [16];
    void'($urandom(SEED));
    n_chk          = 0;
    n_err          = 0;
    done           = 1'b0;
    rst_n          = 1'b0;
    lk_pc          = '0;
    up_valid       = 1'b0;
    up_pc          = '0;
    up_taken       = 1'b0;
    up_global_pred = 1'b0;
    up_local_pred  = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at several addresses
    for (int i = 0; i < 6; i++) begin
      logic [31:0] pc;
      pc = 32'h0000_1000 + i * 32'h44;
      probe(pc, "R1 reset");
      chk("R1", "reset", "pred_after_reset", lk_pred, 1'b0);
    end

    // R6: saturation runs on one branch
    for (int i = 0; i < 40; i++) branch(32'h0000_0040, 1'b1, "R6 sat-up");
    for (int i = 0; i < 40; i++) branch(32'h0000_0040, 1'b0, "R6 sat-down");

    // R5: loop branch, seven taken then one exit
    for (int r = 0; r < 30; r++) begin
      for (int k = 0; k < 8; k++) branch(32'h0000_0080, (k != 7), "R5 loop");
    end

    // R2: aliasing addresses sharing PC[7:2]
    for (int i = 0; i < 40; i++) begin
      branch(32'h0000_0104, 1'b1, "R2 alias");
      branch(32'h0000_0004, 1'b0, "R2 alias");
      branch(32'h0001_0104, 1'($urandom), "R2 alias");
    end

    // R8: update inputs move while the strobe is low
    for (int i = 0; i < 20; i++) begin
      logic [31:0] pc;
      pc = 32'h0000_0080 + (i % 4) * 4;
      idle_noise();
      probe(pc, "R8 idle");
    end

    // R7 / R9: biased random stream exercises disagreement and same-cycle update
    for (int i = 0; i < 16; i++) bias[i] = $urandom_range(0, 100);
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [31:0] pc;
      sel = $urandom_range(0, 15);
      pc  = 32'h0000_2000 + sel * 4 + (($urandom % 4) << 8);
      branch(pc, ($urandom_range(0, 99) < bias[sel]), (i % 2 == 0) ? "R7 random" : "R9 random");
    end

    // R8: final idle check after the random stream
    for (int i = 0; i < 8; i++) begin
      idle_noise();
      probe(32'h0000_2000 + i * 4, "R8 idle-end");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule